// File: doc/BRIEF.md
# Reset Cause and Software Reset Register

This block keeps a small record of why the system last came out of reset, and gives software a way to ask for a new reset. It presents one 32-bit word. Only the top five bits hold state. Bit 31 marks a power-on start. Bits 30 and 29 are command bits: bit 30 requests a full software power-on reset and bit 29 requests a software external-style reset. Bits 28 and 27 are cause flags for reset buttons. This block never sets them, but software clears them the same way as bit 31. Every other bit reads as zero.

A system reset sequencer, outside this block, pulses `sys_rst_done` once each time the system completes a reset. The block counts these events in a saturating counter. On the first event after power-up, or the first event after software re-arms the count, the word is loaded with only bit 31 set. Later events leave the word as it is. A software write that sets either command bit produces a single-cycle pulse on `reset_req` in the next cycle. The sequencer acts on that pulse. `rst_n` is the power-up reset of the block itself. Its assertion is asynchronous and its release must be synchronous to `clk`.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `rst_n` is low and directly after it is released, `rd_data` reads 0x00000000 and `reset_req` is low.
- R2: `rd_data` bits 26:0 always read zero, and write data in bits 26:0 has no effect on the stored word.
- R3: Bits 31, 28 and 27 are write-one-to-clear. A write with one of these bits at 1 clears that bit in the next cycle. A write with the bit at 0 leaves it unchanged. A write can never set these bits.
- R4: Bits 30 and 29 take the written value in the cycle after the write.
- R5: A write with bit 30 or bit 29 at 1 drives `reset_req` high for exactly the one cycle that follows the write. A write with both bits at 0 gives no pulse.
- R6: The first `sys_rst_done` pulse after `rst_n` is released loads the word with 0x80000000, replacing every other stored bit.
- R7: A `sys_rst_done` pulse that is not a first event leaves `rd_data` unchanged.
- R8: A write with bit 30 at 1 re-arms first-event tracking, so the next `sys_rst_done` pulse again loads 0x80000000.
- R9: The reset-event counter (CNT_W bits) saturates, so a long run of `sys_rst_done` pulses without a re-arm never reloads bit 31.
- R10: When `wr_en` and `sys_rst_done` are high in the same cycle, the reset event wins. The write has no effect on the word, the tracking or `reset_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous assert, synchronous release |
| sys_rst_done | input | 1 | One-cycle pulse from the sequencer each time a system reset completes |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Register write data |
| rd_data | output | DATA_W | Current register word; state in bits 31:27 only |
| reset_req | output | 1 | One-cycle system reset request, registered after a command write |

## Verification
If the event counter is wrong, the symptom shows up only on the next `sys_rst_done` pulse. It appears one cycle later as bit 31 reloaded when it should not be, or missing when it should be there. That is why the tests clear bit 31 before they send events. A fault in the write-one-to-clear or write-through bit types shows in `rd_data` one cycle after the write. A fault in request generation shows as a missing, stretched or stray `reset_req` in the cycle after a write, including a write that collides with a reset event.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

  // Implemented field sits at the top of the word
  localparam int unsigned FLD_W   = 5;
  localparam int unsigned FLD_LSB = 27;

  // Field-relative positions of the two command bits
  localparam int unsigned CMD_PWR_IDX = 3;  // word bit 30
  localparam int unsigned CMD_EXT_IDX = 2;  // word bit 29

  // Per-bit access type inside the field
  localparam logic [FLD_W-1:0] CLR_ON_ONE = 5'b10011;  // bits 31, 28, 27
  localparam logic [FLD_W-1:0] WRITE_THRU = 5'b01100;  // bits 30, 29

  // Value loaded on a first reset event
  localparam logic [FLD_W-1:0] FIRST_VAL  = 5'b10000;

endpackage

// File: rtl/rst_cause_field.sv
module rst_cause_field
  import rst_cause_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_first,
  input  logic             wr_go,
  input  logic [FLD_W-1:0] wr_fld,
  output logic [FLD_W-1:0] fld_q
);

  logic [FLD_W-1:0] wr_val;
  logic [FLD_W-1:0] fld_d;
  logic             fld_en;

  // Each bit gets its access type from the package masks
  for (genvar b = 0; b < FLD_W; b++) begin : g_bit
    if (CLR_ON_ONE[b]) begin : g_w1c
      assign wr_val[b] = fld_q[b] & ~wr_fld[b];
    end else if (WRITE_THRU[b]) begin : g_rw
      assign wr_val[b] = wr_fld[b];
    end else begin : g_ro
      assign wr_val[b] = fld_q[b];
    end
  end

  assign fld_en = load_first | wr_go;

  always_comb begin
    fld_d = fld_q;
    if (load_first) begin
      fld_d = FIRST_VAL;
    end else if (wr_go) begin
      fld_d = wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q <= '0;
    end else if (fld_en) begin
      fld_q <= fld_d;
    end
  end

endmodule

// File: rtl/rst_cause_boot.sv
module rst_cause_boot #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic rearm,
  output logic first_boot
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en     = evt | rearm;
  assign first_boot = (cnt_q == '0);

  // An event always wins over a re-arm
  always_comb begin
    cnt_d = cnt_q;
    if (evt) begin
      if (cnt_q != CNT_MAX) begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (rearm) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/rst_cause_req.sv
module rst_cause_req (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic req_q
);

  logic req_d;

  assign req_d = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_rst_done,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              reset_req
);

  localparam int unsigned LOW_W = FLD_LSB;

  logic [FLD_W-1:0] wr_fld;
  logic [FLD_W-1:0] fld_q;
  logic             wr_go;
  logic             first_boot;
  logic             load_first;
  logic             rearm;
  logic             fire;
  logic             unused_low;

  assign wr_fld     = wr_data[FLD_LSB +: FLD_W];
  assign unused_low = ^wr_data[LOW_W-1:0];

  // A reset event in the same cycle suppresses the write (R10)
  assign wr_go      = wr_en & ~sys_rst_done;
  assign load_first = sys_rst_done & first_boot;
  assign rearm      = wr_go & wr_fld[CMD_PWR_IDX];
  assign fire       = wr_go & (wr_fld[CMD_PWR_IDX] | wr_fld[CMD_EXT_IDX]);

  rst_cause_field u_field (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_first (load_first),
    .wr_go      (wr_go),
    .wr_fld     (wr_fld),
    .fld_q      (fld_q)
  );

  rst_cause_boot #(
    .CNT_W (CNT_W)
  ) u_boot (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (sys_rst_done),
    .rearm      (rearm),
    .first_boot (first_boot)
  );

  rst_cause_req u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .req_q (reset_req)
  );

  assign rd_data = {fld_q, {LOW_W{1'b0}}};

endmodule

// File: rtl/rst_cause_ctrl_chk.sv
module rst_cause_ctrl_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sys_rst_done,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              reset_req,
  input logic              first_boot
);

  logic cmd_wr;
  assign cmd_wr = wr_en && !sys_rst_done && (wr_data[30] || wr_data[29]);

  // R5
  req_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> reset_req);

  // R5
  no_req_without_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> !reset_req);

  // R6
  first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_done && first_boot) |=> (rd_data == 32'h8000_0000));

  // R7
  later_evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_done && !first_boot) |=> $stable(rd_data));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sys_rst_done && wr_data[31]) |=> !rd_data[31]);

  // R4
  cmd_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sys_rst_done) |=> (rd_data[30:29] == $past(wr_data[30:29])));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !sys_rst_done) |=> $stable(rd_data));

endmodule

bind rst_cause_ctrl rst_cause_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sys_rst_done (sys_rst_done),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .reset_req    (reset_req),
  .first_boot   (first_boot)
);

// File: tb/rst_cause_ctrl_test.sv
`timescale 1ns/1ps
module rst_cause_ctrl_test;

  logic        clk;
  logic        rst_n;
  logic        sys_rst_done;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        reset_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  rst_cause_ctrl uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sys_rst_done (sys_rst_done),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .reset_req    (reset_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive a write for one cycle; returns at the negedge after the capturing edge
  task automatic do_write(input logic [31:0] d, input logic with_evt);
    @(negedge clk);
    wr_en        = 1'b1;
    wr_data      = d;
    sys_rst_done = with_evt;
    @(negedge clk);
    wr_en        = 1'b0;
    wr_data      = '0;
    sys_rst_done = 1'b0;
  endtask

  task automatic do_evt();
    @(negedge clk);
    sys_rst_done = 1'b1;
    @(negedge clk);
    sys_rst_done = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 reset_req", {31'b0, reset_req}, 32'h0);
  endtask

  task automatic t_first_and_later();
    do_evt();
    check("R6 first event", rd_data, 32'h8000_0000);
    do_evt();
    check("R7 later event", rd_data, 32'h8000_0000);
  endtask

  task automatic t_w1c();
    do_write(32'h0000_0000, 1'b0);
    check("R3 zero keeps", rd_data, 32'h8000_0000);
    check("R5 no pulse", {31'b0, reset_req}, 32'h0);
    do_write(32'h9800_0000, 1'b0);
    check("R3 one clears", rd_data, 32'h0);
  endtask

  task automatic t_cmd();
    do_write(32'h2000_0000, 1'b0);
    check("R4 bit29 set", rd_data, 32'h2000_0000);
    check("R5 pulse high", {31'b0, reset_req}, 32'h1);
    @(negedge clk);
    check("R5 pulse one cycle", {31'b0, reset_req}, 32'h0);
    do_write(32'h07FF_FFFF, 1'b0);
    check("R2 low bits ignored", rd_data, 32'h0);
    check("R2 no pulse", {31'b0, reset_req}, 32'h0);
  endtask

  task automatic t_rearm();
    do_write(32'h4000_0000, 1'b0);
    check("R4 bit30 set", rd_data, 32'h4000_0000);
    check("R5 pulse bit30", {31'b0, reset_req}, 32'h1);
    do_evt();
    check("R8 rearmed load", rd_data, 32'h8000_0000);
  endtask

  task automatic t_collision();
    do_write(32'h6000_0000, 1'b1);
    check("R10 write ignored", rd_data, 32'h8000_0000);
    check("R10 no pulse", {31'b0, reset_req}, 32'h0);
  endtask

  task automatic t_saturate();
    do_write(32'h8000_0000, 1'b0);
    check("R3 clear before sat", rd_data, 32'h0);
    for (int k = 0; k < 20; k++) do_evt();
    check("R9 no reload after many events", rd_data, 32'h0);
  endtask

  initial begin
    rst_n        = 1'b0;
    sys_rst_done = 1'b0;
    wr_en        = 1'b0;
    wr_data      = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_and_later();
    t_w1c();
    t_cmd();
    t_rearm();
    t_collision();
    t_saturate();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule